// File: doc/BRIEF.md
# Three-Phase Dead-Time PWM Generator

This block drives the six gate signals of a three-phase voltage-source inverter: one high-side and one low-side output for each of the phases A, B and C, all active high. A center-aligned up/down counter sweeps the programmed half period. Each phase compares the counter against its own duty value to form a complementary pair. Every turn-on edge is then delayed by a programmable dead time, so that the two switches of a leg are never on together.

On top of this plain dead-time PWM the block can drop pulses that are too narrow to switch cleanly. It can swap the high and low waveforms of any pair, which helps block commutation of brushless motors. It can mask any single output. It can also gate every output with a square chopping wave, so that pulse transformers can carry the drive. Period, duty, dead time and minimum width are captured only when a new PWM cycle starts. The output pins are registered and are held low during reset.

Top module: `pwm3_gen`

## Requirements
- R1: While `rst` is high, all six outputs are low from the first clock edge onward.
- R2: A PWM cycle lasts 2·P clocks, where P is `period_i` and a value of 0 is taken as 1. The raw high-side on time of a phase is 2·min(D, P) clocks, where D is its duty value, and the raw low side is the rest of the cycle. A duty of P or more keeps the high side on without a break.
- R3: Each output's rising edge is delayed by `deadtime_i` clocks, so a raw pulse of W clocks comes out as max(W − dead time, 0) clocks. A waveform that is on for the whole cycle stays on. The high and low output of a pair are never both high.
- R4: The high-side raw width is tested first: if it is nonzero and below `minpulse_i`, the phase acts as duty 0. Otherwise, if the low-side raw width is nonzero and below `minpulse_i`, the phase acts as full duty.
- R5: Period, duty, dead time and minimum width are captured only at the start of a PWM cycle. A change made partway through a cycle takes effect at the next cycle. The pins lag the counter by two clocks.
- R6: `seg_i[5:0]` enables AH, AL, BH, BL, CH, CL in that bit order (bit 0 = AH). A 0 holds that pin low.
- R7: `seg_i[6]`, `seg_i[7]` and `seg_i[8]` swap the high and low waveforms of pairs A, B and C. The swap happens before the enable mask, which still applies per pin.
- R8: When `gate_i[8]` is 1, every output is ANDed with a square wave that is high for N+1 clocks and then low for N+1 clocks, where N is `gate_i[7:0]`. When `gate_i[8]` is 0, no chopping is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_i | input | CW | Half period P in clocks |
| deadtime_i | input | DW | Turn-on delay in clocks |
| minpulse_i | input | CW | Minimum raw pulse width in clocks |
| duty_a_i | input | CW | Duty value, phase A |
| duty_b_i | input | CW | Duty value, phase B |
| duty_c_i | input | CW | Duty value, phase C |
| seg_i | input | 9 | [5:0] pin enables, [8:6] pair swaps |
| gate_i | input | GW+1 | [GW-1:0] chop divider N, [GW] chop enable |
| ah_o | output | 1 | Phase A high side |
| al_o | output | 1 | Phase A low side |
| bh_o | output | 1 | Phase B high side |
| bl_o | output | 1 | Phase B low side |
| ch_o | output | 1 | Phase C high side |
| cl_o | output | 1 | Phase C low side |

## Verification
The bench builds the block with CW=5 and DW=3, so it can sweep half periods up to 9, every duty from 0 to one past P, and dead times and minimum widths that are as large as the pulses themselves. That brings full-on, full-off and suppressed pulses into every phase in the same run. With the timing known exactly from reset, a duty change made mid-cycle can be placed on a precise clock. Chop dividers of 0 and 3 make the gated on-count exact over whole chop periods.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int NPAIR = 3;
  localparam int NOUT  = 2 * NPAIR;
  typedef enum logic { DIR_UP = 1'b0, DIR_DN = 1'b1 } dir_t;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CW-1:0]              period_i,
  input  logic [CW-1:0]              min_i,
  input  logic [DW-1:0]              dt_i,
  input  logic [NPAIR-1:0][CW-1:0]   duty_i,
  output logic [CW-1:0]              cnt_o,
  output logic                       up_o,
  output logic [CW-1:0]              per_o,
  output logic [NPAIR-1:0][CW-1:0]   duty_o,
  output logic [DW-1:0]              dt_o
);
  localparam int WW = CW + 1;

  // duty after clamping to the period and applying the minimum-width rule
  function automatic logic [CW-1:0] eff_duty(input logic [CW-1:0] d,
                                             input logic [CW-1:0] p,
                                             input logic [CW-1:0] m);
    logic [CW-1:0] dc;
    logic [WW-1:0] hw, lw, mw;
    dc = (d > p) ? p : d;
    hw = {dc, 1'b0};
    lw = {p, 1'b0} - hw;
    mw = {1'b0, m};
    if (hw != '0 && hw < mw) return '0;
    if (lw != '0 && lw < mw) return p;
    return dc;
  endfunction

  dir_t                     dir_q;
  logic [CW-1:0]            cnt_q, per_q, per_next;
  logic [NPAIR-1:0][CW-1:0] duty_q;
  logic [DW-1:0]            dt_q;
  logic                     load;

  assign per_next = (period_i == '0) ? {{(CW-1){1'b0}}, 1'b1} : period_i;
  assign load     = (dir_q == DIR_DN) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= DIR_DN;
      cnt_q  <= '0;
      per_q  <= {{(CW-1){1'b0}}, 1'b1};
      duty_q <= '0;
      dt_q   <= '0;
    end else if (load) begin
      dir_q <= DIR_UP;
      cnt_q <= '0;
      per_q <= per_next;
      dt_q  <= dt_i;
      for (int i = 0; i < NPAIR; i++)
        duty_q[i] <= eff_duty(duty_i[i], per_next, min_i);
    end else if (dir_q == DIR_UP) begin
      if (cnt_q == per_q - 1'b1) dir_q <= DIR_DN;
      else                       cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign up_o   = (dir_q == DIR_UP);
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign dt_o   = dt_q;
endmodule

// File: rtl/pwm3_pair.sv
module pwm3_pair #(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] duty_i,
  input  logic [DW-1:0] dt_i,
  output logic          hi_o,
  output logic          lo_o
);
  logic [1:0] raw, q;

  assign raw[0] = (cnt_i < duty_i);
  assign raw[1] = ~raw[0];

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [DW-1:0] dly_q;
    logic          on_q;
    always_ff @(posedge clk) begin
      if (rst || !raw[s]) begin
        dly_q <= '0;
        on_q  <= 1'b0;
      end else if (dly_q >= dt_i) begin
        on_q  <= 1'b1;
      end else begin
        dly_q <= dly_q + 1'b1;
      end
    end
    assign q[s] = on_q;
  end

  assign hi_o = q[0];
  assign lo_o = q[1];
endmodule

// File: rtl/pwm3_chop.sv
module pwm3_chop #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] div_i,
  output logic          wave_o
);
  logic [GW-1:0] cnt_q;
  logic          ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (cnt_q >= div_i) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wave_o = ph_q;
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 8,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_i,
  input  logic [DW-1:0] deadtime_i,
  input  logic [CW-1:0] minpulse_i,
  input  logic [CW-1:0] duty_a_i,
  input  logic [CW-1:0] duty_b_i,
  input  logic [CW-1:0] duty_c_i,
  input  logic [8:0]    seg_i,
  input  logic [GW:0]   gate_i,
  output logic          ah_o,
  output logic          al_o,
  output logic          bh_o,
  output logic          bl_o,
  output logic          ch_o,
  output logic          cl_o
);
  localparam int SEGW = NOUT + NPAIR;

  logic [NPAIR-1:0][CW-1:0] duty_in, act_duty;
  logic [CW-1:0]            cnt, per_act;
  logic [DW-1:0]            dt_act;
  logic                     up;
  logic [NPAIR-1:0]         q_hi, q_lo;
  logic [NOUT-1:0]          pre, pins;
  logic                     chop, pass;

  assign duty_in = {duty_c_i, duty_b_i, duty_a_i};

  pwm3_timebase #(.CW(CW), .DW(DW)) u_tb (
    .clk(clk), .rst(rst), .period_i(period_i), .min_i(minpulse_i),
    .dt_i(deadtime_i), .duty_i(duty_in), .cnt_o(cnt), .up_o(up),
    .per_o(per_act), .duty_o(act_duty), .dt_o(dt_act)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm3_pair #(.CW(CW), .DW(DW)) u_pair (
      .clk(clk), .rst(rst), .cnt_i(cnt), .duty_i(act_duty[p]),
      .dt_i(dt_act), .hi_o(q_hi[p]), .lo_o(q_lo[p])
    );
    assign pre[2*p]   = seg_i[NOUT+p] ? q_lo[p] : q_hi[p];
    assign pre[2*p+1] = seg_i[NOUT+p] ? q_hi[p] : q_lo[p];
  end

  pwm3_chop #(.GW(GW)) u_chop (
    .clk(clk), .rst(rst), .div_i(gate_i[GW-1:0]), .wave_o(chop)
  );

  assign pass = chop | ~gate_i[GW];

  always_ff @(posedge clk) begin
    if (rst) pins <= '0;
    else     pins <= pre & seg_i[NOUT-1:0] & {NOUT{pass}};
  end

  assign {cl_o, ch_o, bl_o, bh_o, al_o, ah_o} = pins;

  logic unused_seg;
  assign unused_seg = ^seg_i[SEGW-1:0] & 1'b0;
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk
  import pwm3_pkg::*;
#(
  parameter int CW = 12,
  parameter int GW = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [CW-1:0]            cnt,
  input logic                     up,
  input logic [CW-1:0]            per_act,
  input logic [NPAIR-1:0][CW-1:0] act_duty,
  input logic [NPAIR-1:0]         q_hi,
  input logic [NPAIR-1:0]         q_lo,
  input logic [8:0]               seg_i,
  input logic [GW:0]              gate_i,
  input logic                     chop,
  input logic [NOUT-1:0]          pins
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk)
    if (rst_d) AST_RESET_LOW: assert (pins == '0); // R1

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < per_act); // R2

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (q_hi & q_lo) == '0); // R3

  AST_LOAD_AT_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_duty) |-> (cnt == '0 && up)); // R5

  for (genvar k = 0; k < NOUT; k++) begin : g_mask
    AST_MASKED_LOW: assert property (@(posedge clk) disable iff (rst)
      !seg_i[k] |=> !pins[k]); // R6
  end

  AST_CHOP_BLANKS: assert property (@(posedge clk) disable iff (rst)
    (gate_i[GW] && !chop) |=> (pins == '0)); // R8
endmodule

bind pwm3_gen pwm3_chk #(.CW(CW), .GW(GW)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .up(up), .per_act(per_act),
  .act_duty(act_duty), .q_hi(q_hi), .q_lo(q_lo), .seg_i(seg_i),
  .gate_i(gate_i), .chop(chop), .pins(pins)
);

// File: tb/sim_pwm3_gen.sv
module sim_pwm3_gen;
  localparam int CW = 5;
  localparam int DW = 3;
  localparam int GW = 8;
  localparam int TCLK = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] period_i = '0, minpulse_i = '0;
  logic [CW-1:0] duty_a_i = '0, duty_b_i = '0, duty_c_i = '0;
  logic [DW-1:0] deadtime_i = '0;
  logic [8:0]    seg_i = 9'h03F;
  logic [GW:0]   gate_i = '0;
  logic ah_o, al_o, bh_o, bl_o, ch_o, cl_o;
  logic [5:0] pins;

  int checks = 0;
  int errors = 0;
  int on_cnt[6];
  int ovl;

  always #(TCLK/2) clk = ~clk;

  pwm3_gen #(.CW(CW), .DW(DW), .GW(GW)) u0 (
    .clk(clk), .rst(rst), .period_i(period_i), .deadtime_i(deadtime_i),
    .minpulse_i(minpulse_i), .duty_a_i(duty_a_i), .duty_b_i(duty_b_i),
    .duty_c_i(duty_c_i), .seg_i(seg_i), .gate_i(gate_i),
    .ah_o(ah_o), .al_o(al_o), .bh_o(bh_o), .bl_o(bl_o), .ch_o(ch_o), .cl_o(cl_o)
  );

  assign pins = {cl_o, ch_o, bl_o, bh_o, al_o, ah_o};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic win(input int n);
    for (int k = 0; k < 6; k++) on_cnt[k] = 0;
    ovl = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int k = 0; k < 6; k++) on_cnt[k] += int'(pins[k]);
      if ((ah_o & al_o) | (bh_o & bl_o) | (ch_o & cl_o)) ovl++;
    end
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  // raw high width in clocks after clamping and the minimum-width rule (R2, R4)
  function automatic int raw_hi(input int d, input int p, input int m);
    int dc, hw, lw;
    dc = (d > p) ? p : d;
    hw = 2 * dc;
    lw = 2 * p - hw;
    if (hw != 0 && hw < m) return 0;
    if (lw != 0 && lw < m) return 2 * p;
    return hw;
  endfunction

  // output on-count per cycle after dead time (R3)
  function automatic int on_exp(input int raw, input int p, input int dt);
    if (raw == 2 * p) return 2 * p;
    if (raw <= dt) return 0;
    return raw - dt;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int plist[5] = '{1, 2, 3, 6, 9};
    int dlist[3] = '{0, 2, 5};
    int mlist[3] = '{0, 3, 5};

    // R1: reset holds outputs low
    period_i = 5'd8; duty_a_i = 5'd2; duty_b_i = 5'd2; duty_c_i = 5'd2;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", int'(pins), 0);
    end

    // R5: mid-cycle duty change waits for next cycle start
    rst = 1'b0;
    repeat (20) @(negedge clk);
    duty_a_i = 5'd6;
    win(14);
    chk("R5 old duty kept", on_cnt[0], 2);
    win(16);
    chk("R5 new duty applied", on_cnt[0], 12);

    // R2/R3/R4 sweep
    for (int pi = 0; pi < 5; pi++) begin
      for (int d = 0; d <= plist[pi] + 1; d++) begin
        for (int di = 0; di < 3; di++) begin
          for (int mi = 0; mi < 3; mi++) begin
            int p, dt, m;
            int dv[3];
            p = plist[pi]; dt = dlist[di]; m = mlist[mi];
            dv[0] = d; dv[1] = (p >= d) ? p - d : 0; dv[2] = d / 2;
            period_i = 5'(p); deadtime_i = 3'(dt); minpulse_i = 5'(m);
            duty_a_i = 5'(dv[0]); duty_b_i = 5'(dv[1]); duty_c_i = 5'(dv[2]);
            settle();
            win(2 * p);
            for (int ph = 0; ph < 3; ph++) begin
              int rh, dc;
              string tag;
              dc = (dv[ph] > p) ? p : dv[ph];
              rh = raw_hi(dv[ph], p, m);
              tag = (rh != 2 * dc) ? "R4" : ((dt != 0) ? "R3" : "R2");
              chk(tag, on_cnt[2*ph],   on_exp(rh, p, dt));
              chk(tag, on_cnt[2*ph+1], on_exp(2 * p - rh, p, dt));
            end
            chk("R3 overlap", ovl, 0);
          end
        end
      end
    end

    // R2: zero period acts as one
    period_i = 5'd0; deadtime_i = '0; minpulse_i = '0;
    duty_a_i = 5'd1; duty_b_i = 5'd0; duty_c_i = 5'd1;
    settle();
    win(8);
    chk("R2 zero period high", on_cnt[0], 8);
    chk("R2 zero period low", on_cnt[3], 8);

    // R6: per-pin enables
    period_i = 5'd6; deadtime_i = 3'd1;
    duty_a_i = 5'd3; duty_b_i = 5'd3; duty_c_i = 5'd3;
    seg_i = 9'b000_101010;
    settle();
    win(12);
    for (int k = 0; k < 6; k++) chk("R6 mask odd", on_cnt[k], (k % 2 == 1) ? 5 : 0);
    seg_i = 9'b000_010101;
    settle();
    win(12);
    for (int k = 0; k < 6; k++) chk("R6 mask even", on_cnt[k], (k % 2 == 0) ? 5 : 0);

    // R7: pair B swapped
    seg_i = 9'b010_111111;
    duty_a_i = 5'd2; duty_b_i = 5'd2; duty_c_i = 5'd2;
    settle();
    win(12);
    chk("R7 AH", on_cnt[0], 3);
    chk("R7 AL", on_cnt[1], 7);
    chk("R7 BH swapped", on_cnt[2], 7);
    chk("R7 BL swapped", on_cnt[3], 3);
    chk("R7 overlap", ovl, 0);
    seg_i = 9'b010_111011;
    settle();
    win(12);
    chk("R7 swapped BH masked", on_cnt[2], 0);
    chk("R7 swapped BL", on_cnt[3], 3);

    // R8: chopping
    seg_i = 9'h03F;
    period_i = 5'd4; deadtime_i = '0;
    duty_a_i = 5'd4; duty_b_i = 5'd4; duty_c_i = 5'd4;
    gate_i = {1'b1, 8'd0};
    settle();
    win(16);
    chk("R8 chop N0 AH", on_cnt[0], 8);
    chk("R8 chop N0 AL", on_cnt[1], 0);
    gate_i = {1'b1, 8'd3};
    settle();
    win(32);
    chk("R8 chop N3 AH", on_cnt[0], 16);
    chk("R8 chop N3 CH", on_cnt[4], 16);
    gate_i = {1'b0, 8'd3};
    settle();
    win(32);
    chk("R8 chop off AH", on_cnt[0], 32);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule